// File: doc/BRIEF.md
# Tagged Debug Word Bridge

This block sits on a memory-mapped device bus and moves 32-bit words between a processor and an external debug probe. Every word carries a 4-bit channel tag. A processor store to one of sixteen transmit addresses pushes the store data into a transmit FIFO. The tag is the index of the address that was written. A processor load from the receive address pops the oldest word that the probe delivered. Both FIFOs absorb bursts, so software does not wait on the slower transfer to the probe.

A control register holds four access bits. These decide whether supervisor-mode and user-mode code may read or write the data, configuration and status registers. Kernel/debug mode always has full access. A configuration register reports both FIFO depths. A status register reports the fill flags, a sticky transmit-overflow flag and the tag of the oldest received word.

On the probe side, outgoing entries are a valid/ready stream and incoming entries are a valid/ready stream. `tx_valid` stays high and `tx_data` stays stable until the probe raises `tx_ready`. `rx_ready` is low only while the receive FIFO is full. A word moves on every clock edge where valid and ready are both high, so back-to-back transfers run at one entry per clock. Bus reads are combinational from the current state. A load pops, and a store takes effect, at the clock edge that ends the access cycle.

Top module: `dbgchan_bridge`

## Requirements
- R1: After reset both FIFOs are empty, `tx_valid` is low, `rx_ready` is high, the access bits hold ACC_RESET (default 0) and the overflow flag is clear.
- R2: The control register at offset 0x00 reads as DEV_ID in bits 31:24, DEV_SIZE in bits 21:16 and DEV_REV in bits 15:12. Bits 3..0 hold user-write, user-read, supervisor-write and supervisor-read, and every other bit reads 0. Only kernel-mode stores change it, and only bits 3:0 are stored.
- R3: A permitted store to offset 0x20 + 8·n (n = 0..15) pushes {n, data} into the transmit FIFO. Entries leave in store order on `tx_data`, with the tag in bits 35:32 and the data in bits 31:0.
- R4: A permitted load from offset 0x18 returns the oldest received data word and pops it. A load while the receive FIFO is empty returns 0 and pops nothing.
- R5: A store to a transmit address while the transmit FIFO is full is dropped and sets the overflow flag. The flag stays set until reset.
- R6: `bus_priv` is 0 for kernel/debug, 1 for supervisor, and 2 or 3 for user. Supervisor uses access bits 1 (write) and 0 (read). User uses bits 3 (write) and 2 (read). A denied read returns 0 and pops nothing. A denied write changes nothing.
- R7: The status register at offset 0x10 has bit 0 tx full, bit 1 tx empty, bit 2 rx full, bit 3 rx empty, bit 4 overflow, and bits 11:8 the tag of the oldest received word (0 when empty). All other bits are 0.
- R8: The configuration register at offset 0x08 reads TX_DEPTH in bits 7:0 and RX_DEPTH in bits 15:8. Stores to it have no effect.
- R9: `tx_valid` is high exactly when the transmit FIFO holds an entry. `tx_valid` and `tx_data` hold while `tx_ready` is low. `rx_ready` is high exactly when the receive FIFO is not full. Both directions accept one entry per clock.
- R10: Loads from offsets that are not a multiple of 8, that lie outside the map, or that address a transmit register return 0. Stores to offsets that are not a multiple of 8 or that lie outside the map have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this device, one cycle per access |
| bus_wr | input | 1 | 1 = store, 0 = load |
| bus_priv | input | 2 | Privilege of the access (0 kernel, 1 supervisor, 2/3 user) |
| bus_addr | input | ADDR_W | Byte offset inside the device block |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the access cycle |
| tx_valid | output | 1 | Transmit entry available to the probe |
| tx_ready | input | 1 | Probe accepts the transmit entry |
| tx_data | output | 36 | Transmit entry {tag, data} |
| rx_valid | input | 1 | Probe offers a receive entry |
| rx_ready | output | 1 | Receive FIFO can accept an entry |
| rx_data | input | 36 | Receive entry {tag, data} |

## Verification
The bench fills the transmit FIFO and then stores once more. A design that let the extra word in, overwrote the oldest entry, or failed to set the sticky overflow bit gives the wrong drain sequence or status value. It reads the receive register while the FIFO is empty, and again when the access is denied. A design that popped in either case would lose a word and return later data too early. It checks each privilege level against each access bit. Swapping the read and write bits, or the supervisor and user bits, lets a forbidden store through or zeroes a permitted status read. A long random phase runs stores, loads and probe traffic in both directions at once against a queue model. This catches errors in tag encoding, in simultaneous push and pop on a full FIFO, and in handshakes that drop or repeat entries.

// File: rtl/dbgchan_pkg.sv
package dbgchan_pkg;
  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_USER2  = 2'd3
  } priv_e;

  localparam int TAG_W   = 4;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = TAG_W + WORD_W;
  localparam int NUM_CH  = 1 << TAG_W;

  // word indices (byte offset / 8)
  localparam int IDX_CTL  = 0;
  localparam int IDX_CFG  = 1;
  localparam int IDX_STAT = 2;
  localparam int IDX_RX   = 3;
  localparam int IDX_TX0  = 4;
endpackage

// File: rtl/dbgchan_fifo.sv
module dbgchan_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dbgchan_gate.sv
module dbgchan_gate
  import dbgchan_pkg::*;
(
  input  logic [1:0] priv,
  input  logic [3:0] acc,
  input  logic       is_ctl,
  output logic       rd_ok,
  output logic       wr_ok
);
  priv_e p;
  assign p = priv_e'(priv);

  always_comb begin
    unique case (p)
      PRIV_KERNEL: begin rd_ok = 1'b1;   wr_ok = 1'b1;   end
      PRIV_SUPER:  begin rd_ok = acc[0]; wr_ok = acc[1]; end
      default:     begin rd_ok = acc[2]; wr_ok = acc[3]; end
    endcase
    // the control register is always readable, writable only by kernel
    if (is_ctl) begin
      rd_ok = 1'b1;
      wr_ok = (p == PRIV_KERNEL);
    end
  end
endmodule

// File: rtl/dbgchan_bridge.sv
module dbgchan_bridge
  import dbgchan_pkg::*;
#(
  parameter int         TX_DEPTH  = 8,
  parameter int         RX_DEPTH  = 8,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] DEV_ID    = 8'hFD,
  parameter logic [5:0] DEV_SIZE  = 6'd1,
  parameter logic [3:0] DEV_REV   = 4'd0,
  parameter logic [3:0] ACC_RESET = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_priv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [35:0]       tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [35:0]       rx_data
);
  localparam int IDXW = ADDR_W - 3;
  localparam int TCW  = $clog2(TX_DEPTH + 1);
  localparam int RCW  = $clog2(RX_DEPTH + 1);

  logic [3:0]      acc_bits;
  logic            ovf_flag;
  logic            aligned;
  logic [IDXW-1:0] idx;
  logic            hit_ctl, hit_cfg, hit_stat, hit_rx, hit_tx;
  logic [NUM_CH-1:0] tx_hit;
  logic [TAG_W-1:0]  tx_tag;
  logic            rd_acc, wr_acc, rd_ok, wr_ok;
  logic            tx_push, rx_pop;
  logic [ENTRY_W-1:0] tx_head, rx_head;
  logic [TCW-1:0]  tx_cnt;
  logic [RCW-1:0]  rx_cnt;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [TAG_W-1:0] rx_tag;

  // address decode
  assign aligned  = (bus_addr[2:0] == 3'b000);
  assign idx      = bus_addr[ADDR_W-1:3];
  assign hit_ctl  = aligned && (idx == IDXW'(IDX_CTL));
  assign hit_cfg  = aligned && (idx == IDXW'(IDX_CFG));
  assign hit_stat = aligned && (idx == IDXW'(IDX_STAT));
  assign hit_rx   = aligned && (idx == IDXW'(IDX_RX));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_txdec
    assign tx_hit[c] = aligned && (idx == IDXW'(IDX_TX0 + c));
  end
  assign hit_tx = |tx_hit;

  always_comb begin
    tx_tag = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (tx_hit[c]) tx_tag = TAG_W'(c);
  end

  assign rd_acc = bus_sel && !bus_wr;
  assign wr_acc = bus_sel && bus_wr;

  dbgchan_gate u_gate (
    .priv   (bus_priv),
    .acc    (acc_bits),
    .is_ctl (hit_ctl),
    .rd_ok  (rd_ok),
    .wr_ok  (wr_ok)
  );

  assign tx_push = wr_acc && hit_tx && wr_ok;
  assign rx_pop  = rd_acc && hit_rx && rd_ok;

  dbgchan_fifo #(.W(ENTRY_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (tx_push),
    .push_data ({tx_tag, bus_wdata}),
    .pop       (tx_ready),
    .head      (tx_head),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  dbgchan_fifo #(.W(ENTRY_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (rx_pop),
    .head      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  assign tx_valid = !tx_empty;
  assign tx_data  = tx_head;
  assign rx_ready = !rx_full;
  assign rx_tag   = rx_empty ? '0 : rx_head[ENTRY_W-1:WORD_W];

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_bits <= ACC_RESET;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_acc && hit_ctl && wr_ok) acc_bits <= bus_wdata[3:0];
      if (tx_push && tx_full)         ovf_flag <= 1'b1;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_acc && rd_ok) begin
      if (hit_ctl)
        bus_rdata = {DEV_ID, 2'b00, DEV_SIZE, DEV_REV, 8'h00, acc_bits};
      else if (hit_cfg)
        bus_rdata = {16'h0000, 8'(RX_DEPTH), 8'(TX_DEPTH)};
      else if (hit_stat)
        bus_rdata = {20'h0, rx_tag, 3'b000, ovf_flag,
                     rx_empty, rx_full, tx_empty, tx_full};
      else if (hit_rx && !rx_empty)
        bus_rdata = rx_head[WORD_W-1:0];
    end
  end
endmodule

// File: rtl/dbgchan_bridge_chk.sv
module dbgchan_bridge_chk #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int ADDR_W   = 8,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [1:0]        bus_priv,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [35:0]       tx_data,
  input logic              rx_ready,
  input logic              ovf_flag,
  input logic [3:0]        acc_bits,
  input logic [TCW-1:0]    tx_cnt,
  input logic [RCW-1:0]    rx_cnt
);
  logic is_tx_addr, is_rx_addr, wr_allowed;
  assign is_tx_addr = (bus_addr[2:0] == 3'b000) &&
                      (bus_addr >= ADDR_W'(8'h20)) && (bus_addr <= ADDR_W'(8'h98));
  assign is_rx_addr = (bus_addr == ADDR_W'(8'h18));
  assign wr_allowed = (bus_priv == 2'd0) ||
                      (bus_priv == 2'd1 && acc_bits[1]) ||
                      (bus_priv[1] && acc_bits[3]);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R5

  AST_DENIED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && is_tx_addr && !wr_allowed && !(tx_valid && tx_ready)
    |=> tx_cnt == $past(tx_cnt)); // R6

  AST_EMPTY_RX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && is_rx_addr && rx_cnt == '0 |-> bus_rdata == 32'h0); // R4

  AST_RX_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt == RCW'(RX_DEPTH) |-> !rx_ready); // R9
endmodule

bind dbgchan_bridge dbgchan_bridge_chk #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_ready(rx_ready), .ovf_flag(ovf_flag), .acc_bits(acc_bits),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/dbgchan_bridge_test.sv
module dbgchan_bridge_test;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_priv = 2'd0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        tx_valid, rx_ready;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [35:0] tx_data;
  logic [35:0] rx_data = 36'h0;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [35:0] txq[$];
  logic [35:0] rxq[$];

  always #2 clk = ~clk;

  dbgchan_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp(input bit txf, input bit txe, input bit rxf,
                                           input bit rxe, input bit ovf, input logic [3:0] tag);
    return {20'h0, tag, 3'b000, ovf, rxe, rxf, txe, txf};
  endfunction

  function automatic logic [31:0] ctl_exp(input logic [3:0] acc);
    return {8'hFD, 2'b00, 6'd1, 4'd0, 8'h00, acc};
  endfunction

  function automatic logic [7:0] tx_addr(input int n);
    return 8'(32'h20 + 8 * n);
  endfunction

  // one bus cycle; returns at the following negedge with the access committed
  task automatic bus_op(input logic [1:0] p, input logic w, input logic [7:0] a,
                        input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_priv = p; bus_addr = a; bus_wdata = d;
    #1 q = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] q;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    #1 check("R1 tx_valid", 36'(tx_valid), 36'd0);
    check("R1 rx_ready", 36'(rx_ready), 36'd1);
    bus_op(2'd0, 1'b0, 8'h00, 0, q); check("R2 ctl reset", 36'(q), 36'(ctl_exp(4'h0)));
    bus_op(2'd0, 1'b0, 8'h10, 0, q); check("R1 status reset", 36'(q), 36'(stat_exp(0,1,0,1,0,0)));

    // R8 config
    bus_op(2'd0, 1'b0, 8'h08, 0, q); check("R8 cfg", 36'(q), 36'h0808);
    bus_op(2'd0, 1'b1, 8'h08, 32'hFFFF_FFFF, q);
    bus_op(2'd0, 1'b0, 8'h08, 0, q); check("R8 cfg read-only", 36'(q), 36'h0808);

    // R6 gating with all access bits clear
    bus_op(2'd2, 1'b1, tx_addr(0), 32'h5555, q);
    #1 check("R6 user store denied", 36'(tx_valid), 36'd0);
    bus_op(2'd3, 1'b0, 8'h10, 0, q); check("R6 user read denied", 36'(q), 36'd0);

    // R2 control writes
    bus_op(2'd0, 1'b1, 8'h00, 32'hFFFF_FFFF, q);
    bus_op(2'd0, 1'b0, 8'h00, 0, q); check("R2 ctl write", 36'(q), 36'(ctl_exp(4'hF)));
    bus_op(2'd1, 1'b1, 8'h00, 32'h0, q);
    bus_op(2'd2, 1'b0, 8'h00, 0, q); check("R2 super write ignored", 36'(q), 36'(ctl_exp(4'hF)));
    bus_op(2'd0, 1'b1, 8'h00, 32'h0000_0006, q); // user-read + supervisor-write

    bus_op(2'd1, 1'b0, 8'h10, 0, q); check("R6 super read denied", 36'(q), 36'd0);
    bus_op(2'd2, 1'b0, 8'h10, 0, q); check("R6 user read allowed", 36'(q), 36'(stat_exp(0,1,0,1,0,0)));
    bus_op(2'd1, 1'b1, tx_addr(5), 32'h0000_1234, q);
    #1 check("R3 super store tag5", tx_data, {4'd5, 32'h0000_1234});
    check("R6 super store allowed", 36'(tx_valid), 36'd1);
    bus_op(2'd2, 1'b1, tx_addr(1), 32'h7777, q);
    bus_op(2'd0, 1'b1, 8'h00, 32'h0, q);

    // R5 fill and overflow
    for (int i = 1; i < D; i++) bus_op(2'd0, 1'b1, tx_addr(i), 32'hA000_0000 + i, q);
    bus_op(2'd0, 1'b0, 8'h10, 0, q); check("R7 tx full", 36'(q), 36'(stat_exp(1,0,0,1,0,0)));
    bus_op(2'd0, 1'b1, tx_addr(15), 32'hDEAD, q);
    bus_op(2'd0, 1'b0, 8'h10, 0, q); check("R5 overflow set", 36'(q), 36'(stat_exp(1,0,0,1,1,0)));

    // R3/R9 drain in order, one per clock
    tx_ready = 1'b1;
    for (int i = 0; i < D; i++) begin
      #1 check("R9 tx_valid drain", 36'(tx_valid), 36'd1);
      check("R3 drain order", tx_data,
            (i == 0) ? {4'd5, 32'h1234} : {4'(i), 32'hA000_0000 + 32'(i)});
      @(negedge clk);
    end
    tx_ready = 1'b0;
    #1 check("R9 tx empty after drain", 36'(tx_valid), 36'd0);
    bus_op(2'd0, 1'b0, 8'h10, 0, q); check("R5 overflow sticky", 36'(q), 36'(stat_exp(0,1,0,1,1,0)));

    // R4 empty rx load
    bus_op(2'd0, 1'b0, 8'h18, 0, q); check("R4 empty rx read", 36'(q), 36'd0);

    // R9 receive burst until full
    for (int k = 0; k < D; k++) begin
      rx_valid = 1'b1; rx_data = {4'(k + 2), 32'hB000_0000 + 32'(k)};
      #1 check("R9 rx_ready burst", 36'(rx_ready), 36'd1);
      @(negedge clk);
    end
    rx_data = 36'hF_FFFF_FFFF;
    #1 check("R9 rx_ready full", 36'(rx_ready), 36'd0);
    @(negedge clk); rx_valid = 1'b0;
    bus_op(2'd0, 1'b0, 8'h10, 0, q); check("R7 rx full tag", 36'(q), 36'(stat_exp(0,1,1,0,1,4'd2)));
    bus_op(2'd2, 1'b0, 8'h18, 0, q); check("R6 denied rx read", 36'(q), 36'd0);
    for (int k = 0; k < D; k++) begin
      bus_op(2'd0, 1'b0, 8'h18, 0, q); check("R4 rx pop order", 36'(q), 36'(32'hB000_0000 + 32'(k)));
    end
    bus_op(2'd0, 1'b0, 8'h18, 0, q); check("R4 rx drained", 36'(q), 36'd0);

    // R10 unmapped and odd offsets
    bus_op(2'd0, 1'b0, 8'h04, 0, q); check("R10 misaligned read", 36'(q), 36'd0);
    bus_op(2'd0, 1'b0, 8'hA0, 0, q); check("R10 unmapped read", 36'(q), 36'd0);
    bus_op(2'd0, 1'b0, tx_addr(3), 0, q); check("R10 tx read", 36'(q), 36'd0);
    bus_op(2'd0, 1'b1, 8'h24, 32'h1, q);
    #1 check("R10 misaligned store", 36'(tx_valid), 36'd0);

    // R1 reset clears overflow and access bits
    bus_op(2'd0, 1'b1, 8'h00, 32'hF, q);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    bus_op(2'd0, 1'b0, 8'h10, 0, q); check("R1 ovf cleared", 36'(q), 36'(stat_exp(0,1,0,1,0,0)));
    bus_op(2'd0, 1'b0, 8'h00, 0, q); check("R1 acc cleared", 36'(q), 36'(ctl_exp(4'h0)));

    // random traffic against queue model (R3 R4 R9)
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int op, ch, tsz, rsz;
      logic [31:0] d;
      @(negedge clk);
      op = $urandom % 4; ch = $urandom % 16; d = $urandom;
      tx_ready = 1'($urandom % 2);
      rx_valid = 1'($urandom % 2);
      rx_data = {4'($urandom % 16), 32'($urandom)};
      bus_priv = 2'd0;
      bus_sel = (op < 2); bus_wr = (op == 0);
      bus_addr = (op == 0) ? tx_addr(ch) : 8'h18;
      bus_wdata = d;
      #1;
      tsz = txq.size(); rsz = rxq.size();
      check("R9 rnd tx_valid", 36'(tx_valid), 36'(tsz != 0));
      if (tsz != 0) check("R3 rnd tx_data", tx_data, txq[0]);
      check("R9 rnd rx_ready", 36'(rx_ready), 36'(rsz < D));
      if (op == 1) check("R4 rnd rx data", 36'(bus_rdata), (rsz != 0) ? 36'(rxq[0][31:0]) : 36'd0);
      if (tsz != 0 && tx_ready) void'(txq.pop_front());
      if (op == 0 && tsz < D) txq.push_back({4'(ch), d});
      if (rx_valid && rsz < D) rxq.push_back(rx_data);
      if (op == 1 && rsz != 0) void'(rxq.pop_front());
    end
    @(negedge clk); bus_sel = 1'b0; tx_ready = 1'b0; rx_valid = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule